// File: doc/BRIEF.md
# Two-Entry Fetch Address Translation Cache

This block sits on the output of the next-fetch-address multiplexer of an instruction fetch stage. It turns an effective fetch address into a real address. Two fully associative entries each hold an effective page number and the real page number it maps to. Pages are 4 KiB, so the low 12 address bits pass through unchanged. When translation is off, the effective address goes out as the real address, and the entries are neither used nor touched.

When translation is on and neither entry matches, the block asks the larger instruction TLB for the page. The outgoing request is held low while that lookup runs. A good answer is written into the least recently used entry, or over an entry that already holds the same page. If the answer is a miss or a protection fault, the block raises fetch-failed and stalls. It leaves the stall when an MMU page-table entry arrives, or when an interrupt or redirect occurs. A PTE offered on the fill port at any time is loaded into the entries. An invalidate strobe clears both entries.

The incoming address is a valid-qualified stream with no ready. The outgoing request (`rq_valid`, `rq_addr`) is a valid-only stream. Back-pressure works by withholding `rq_valid`: while `fa_valid` is high and `rq_valid` is low, the fetch stage must hold `fa_addr` steady. The larger TLB answers on the fill port in the cycle after `lookup_req`.

Top module: `fetch_xlat2`

## Requirements
- R1: Reset sets both entries to invalid, sets the replacement pointer to entry 0 and leaves the stall state, with `fetch_fail` low. The first translated fetch after reset therefore misses.
- R2: With `xlat_en` low and `fa_valid` high in the idle state, `rq_valid` is high and `rq_addr` equals `fa_addr` in the same cycle, and `lookup_req` stays low.
- R3: With `xlat_en` high and a matching valid entry in the idle state, `rq_valid` is high in the same cycle. `rq_addr` is the entry's real page number concatenated with `fa_addr[11:0]`.
- R4: A translated miss in the idle state raises `lookup_req` for one cycle, with `lookup_epn = fa_addr[31:12]`. `rq_valid` is low in that cycle and the next. If the next cycle carries a good fill (`fill_valid` high, `fill_fault` low), the held address is valid and translated in the third cycle.
- R5: A good fill is written over a valid entry whose effective page equals `fill_epn` if one exists; otherwise it goes into the least recently used entry.
- R6: A hit marks the other entry as least recently used. A fill marks the written entry as most recently used.
- R7: If, in the cycle after `lookup_req`, `fill_valid` is low (TLB miss) or `fill_fault` is high (protection violation), then `fetch_fail` is high from the next cycle on. It stays high, with `rq_valid` and `lookup_req` low, until the stall is left.
- R8: While stalled, a cycle with `redirect`, `irq` or a good fill returns the block to idle in the next cycle, where `fetch_fail` is low. A good fill is also loaded into the entries.
- R9: A good fill arriving while idle, with no lookup pending, is loaded into the entries.
- R10: `inval` clears both entries, so the next translated fetch misses. It takes priority over a good fill in the same cycle.
- R11: With `fa_valid` low, `rq_valid` and `lookup_req` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fa_valid | input | 1 | Fetch address valid |
| fa_addr | input | ADDR_W | Effective fetch address |
| xlat_en | input | 1 | Translation enable |
| redirect | input | 1 | Fetch redirect; leaves the stall state |
| irq | input | 1 | Interrupt taken; leaves the stall state |
| inval | input | 1 | Invalidate both entries |
| fill_valid | input | 1 | Answer from larger TLB or PTE from the MMU is present |
| fill_fault | input | 1 | Answer is a protection violation |
| fill_epn | input | ADDR_W-PAGE_BITS | Effective page number of the fill |
| fill_rpn | input | ADDR_W-PAGE_BITS | Real page number of the fill |
| rq_valid | output | 1 | Outgoing fetch request valid |
| rq_addr | output | ADDR_W | Real fetch address |
| lookup_req | output | 1 | Request to the larger TLB |
| lookup_epn | output | ADDR_W-PAGE_BITS | Effective page number to look up |
| fetch_fail | output | 1 | Fetch failed; block is stalled |

## Verification
Untranslated and hit results, and the lookup request on a miss, are due in the same cycle as the address that causes them. A translated miss with a good fill is due in the third cycle. `fetch_fail` rises one cycle after the answer cycle and falls one cycle after the exit event. Invalidates and fills show up on the next fetch. The bench queues one expected item per driven cycle. It drives inputs at the falling edge, and a monitor samples the outputs 5 ns later, before the next rising edge. Each expectation is therefore written for the exact cycle the requirement names.

// File: rtl/fxl_pkg.sv
package fxl_pkg;
  typedef enum logic [1:0] {
    FX_IDLE  = 2'd0,
    FX_WAIT  = 2'd1,
    FX_STALL = 2'd2
  } fx_state_e;
endpackage

// File: rtl/fxl_entries.sv
module fxl_entries #(
  parameter int PN_W = 20,
  localparam int NENT = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PN_W-1:0] look_epn,
  input  logic            touch,
  input  logic            wr_en,
  input  logic [PN_W-1:0] wr_epn,
  input  logic [PN_W-1:0] wr_rpn,
  input  logic            inval,
  output logic            hit,
  output logic [PN_W-1:0] hit_rpn
);
  logic [NENT-1:0] vld_q;
  logic [PN_W-1:0] epn_q [NENT];
  logic [PN_W-1:0] rpn_q [NENT];
  logic            lru_q;
  logic [NENT-1:0] look_m;
  logic [NENT-1:0] wr_m;
  logic            hit_idx;
  logic            wr_idx;

  for (genvar i = 0; i < NENT; i++) begin : g_ent
    assign look_m[i] = vld_q[i] && (epn_q[i] == look_epn);
    assign wr_m[i]   = vld_q[i] && (epn_q[i] == wr_epn);
  end

  assign hit     = |look_m;
  assign hit_idx = look_m[1];
  assign hit_rpn = rpn_q[hit_idx];
  // same page already held: overwrite it, else take the LRU slot (R5)
  assign wr_idx  = (|wr_m) ? wr_m[1] : lru_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      lru_q <= 1'b0;
    end else if (inval) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx] <= 1'b1;
      lru_q         <= ~wr_idx;
    end else if (touch && hit) begin
      lru_q <= ~hit_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && !inval && wr_en) begin
      epn_q[wr_idx] <= wr_epn;
      rpn_q[wr_idx] <= wr_rpn;
    end
  end

  a_r5_single_hit: assert property (@(posedge clk) disable iff (rst)
    $countones(look_m) <= 1);

  a_r6_hit_lru: assert property (@(posedge clk) disable iff (rst)
    (touch && hit && !wr_en && !inval) |=> (lru_q != $past(hit_idx)));

  a_r10_inval_clears: assert property (@(posedge clk) disable iff (rst)
    inval |=> !hit);
endmodule

// File: rtl/fxl_ctrl.sv
module fxl_ctrl
  import fxl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fa_valid,
  input  logic xlat_en,
  input  logic hit,
  input  logic fill_valid,
  input  logic fill_fault,
  input  logic irq,
  input  logic redirect,
  output logic req_valid,
  output logic lookup_req,
  output logic fetch_fail,
  output logic touch
);
  fx_state_e st_q, st_d;
  logic      fill_ok;

  assign fill_ok = fill_valid && !fill_fault;

  always_comb begin
    st_d       = st_q;
    req_valid  = 1'b0;
    lookup_req = 1'b0;
    touch      = 1'b0;
    case (st_q)
      FX_IDLE: begin
        if (fa_valid) begin
          if (!xlat_en) begin
            req_valid = 1'b1;
          end else if (hit) begin
            req_valid = 1'b1;
            touch     = 1'b1;
          end else begin
            lookup_req = 1'b1;
            st_d       = FX_WAIT;
          end
        end
      end
      FX_WAIT: st_d = fill_ok ? FX_IDLE : FX_STALL;
      FX_STALL: if (irq || redirect || fill_ok) st_d = FX_IDLE;
      default: st_d = FX_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= FX_IDLE;
    else     st_q <= st_d;
  end

  assign fetch_fail = (st_q == FX_STALL);

  a_r4_low_after_lookup: assert property (@(posedge clk) disable iff (rst)
    lookup_req |=> (!req_valid && !lookup_req));

  a_r7_fault_stalls: assert property (@(posedge clk) disable iff (rst)
    ($past(lookup_req) && !fill_ok) |=> fetch_fail);

  a_r7_stall_blocks: assert property (@(posedge clk) disable iff (rst)
    fetch_fail |-> (!req_valid && !lookup_req));

  a_r8_stall_exit: assert property (@(posedge clk) disable iff (rst)
    (fetch_fail && (irq || redirect || fill_ok)) |=> !fetch_fail);
endmodule

// File: rtl/fetch_xlat2.sv
module fetch_xlat2 #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  localparam int PN_W     = ADDR_W - PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fa_valid,
  input  logic [ADDR_W-1:0] fa_addr,
  input  logic              xlat_en,
  input  logic              redirect,
  input  logic              irq,
  input  logic              inval,
  input  logic              fill_valid,
  input  logic              fill_fault,
  input  logic [PN_W-1:0]   fill_epn,
  input  logic [PN_W-1:0]   fill_rpn,
  output logic              rq_valid,
  output logic [ADDR_W-1:0] rq_addr,
  output logic              lookup_req,
  output logic [PN_W-1:0]   lookup_epn,
  output logic              fetch_fail
);
  logic            hit;
  logic            touch;
  logic [PN_W-1:0] hit_rpn;
  logic            wr_en;

  assign lookup_epn = fa_addr[ADDR_W-1:PAGE_BITS];
  assign wr_en      = fill_valid && !fill_fault;

  fxl_entries #(.PN_W(PN_W)) u_ent (
    .clk      (clk),
    .rst      (rst),
    .look_epn (lookup_epn),
    .touch    (touch),
    .wr_en    (wr_en),
    .wr_epn   (fill_epn),
    .wr_rpn   (fill_rpn),
    .inval    (inval),
    .hit      (hit),
    .hit_rpn  (hit_rpn)
  );

  fxl_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .fa_valid   (fa_valid),
    .xlat_en    (xlat_en),
    .hit        (hit),
    .fill_valid (fill_valid),
    .fill_fault (fill_fault),
    .irq        (irq),
    .redirect   (redirect),
    .req_valid  (rq_valid),
    .lookup_req (lookup_req),
    .fetch_fail (fetch_fail),
    .touch      (touch)
  );

  assign rq_addr = xlat_en ? {hit_rpn, fa_addr[PAGE_BITS-1:0]} : fa_addr;

  a_r2_passthru: assert property (@(posedge clk) disable iff (rst)
    (rq_valid && !xlat_en) |-> (rq_addr == fa_addr));

  a_r3_offset_kept: assert property (@(posedge clk) disable iff (rst)
    rq_valid |-> (rq_addr[PAGE_BITS-1:0] == fa_addr[PAGE_BITS-1:0]));

  a_r11_no_input: assert property (@(posedge clk) disable iff (rst)
    !fa_valid |-> (!rq_valid && !lookup_req));
endmodule

// File: tb/fetch_xlat2_bench.sv
module fetch_xlat2_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fa_valid = 1'b0, xlat_en = 1'b0, redirect = 1'b0, irq = 1'b0, inval = 1'b0;
  logic        fill_valid = 1'b0, fill_fault = 1'b0;
  logic [31:0] fa_addr = '0;
  logic [19:0] fill_epn = '0, fill_rpn = '0;
  logic        rq_valid, lookup_req, fetch_fail;
  logic [31:0] rq_addr;
  logic [19:0] lookup_epn;

  always #10 clk = ~clk;

  fetch_xlat2 u_fetch_xlat2 (
    .clk(clk), .rst(rst), .fa_valid(fa_valid), .fa_addr(fa_addr), .xlat_en(xlat_en),
    .redirect(redirect), .irq(irq), .inval(inval), .fill_valid(fill_valid),
    .fill_fault(fill_fault), .fill_epn(fill_epn), .fill_rpn(fill_rpn),
    .rq_valid(rq_valid), .rq_addr(rq_addr), .lookup_req(lookup_req),
    .lookup_epn(lookup_epn), .fetch_fail(fetch_fail)
  );

  typedef struct {
    logic        rv;
    logic [31:0] ra;
    bit          cra;
    logic        lk;
    logic [19:0] lke;
    logic        ff;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  localparam logic [19:0] PA = 20'h00010, RA = 20'hA0A0A;
  localparam logic [19:0] PB = 20'h00020, RB = 20'hB0B0B, RB2 = 20'hB2B2B;
  localparam logic [19:0] PC = 20'h00030, RC = 20'hC0C0C;
  localparam logic [19:0] PD = 20'h00040, RD = 20'hD0D0D;
  localparam logic [11:0] OF = 12'h123;
  localparam logic [31:0] XU = 32'h1234_5678;

  task automatic chk1(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic chkw(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and queue what the outputs must show
  task automatic cyc(input logic v, input logic [31:0] a, input logic x,
                     input logic fv, input logic flt, input logic [19:0] fe, input logic [19:0] fr,
                     input logic inv, input logic ir, input logic rd,
                     input logic e_rv, input logic [31:0] e_ra, input bit e_cra,
                     input logic e_lk, input logic e_ff, input string tag);
    exp_t e;
    @(negedge clk);
    fa_valid = v; fa_addr = a; xlat_en = x;
    fill_valid = fv; fill_fault = flt; fill_epn = fe; fill_rpn = fr;
    inval = inv; irq = ir; redirect = rd;
    e.rv = e_rv; e.ra = e_ra; e.cra = e_cra; e.lk = e_lk; e.lke = a[31:12]; e.ff = e_ff; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: sample 5 ns after the falling edge, before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk1(e.tag, "rq_valid", rq_valid, e.rv);
        chk1(e.tag, "lookup_req", lookup_req, e.lk);
        chk1(e.tag, "fetch_fail", fetch_fail, e.ff);
        if (e.cra) chkw(e.tag, "rq_addr", rq_addr, e.ra);
        if (e.lk)  chkw(e.tag, "lookup_epn", {12'h0, lookup_epn}, {12'h0, e.lke});
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state, then first translated fetch misses
    cyc(0, '0, 1, 0,0,'0,'0, 0,0,0,  0, '0, 0, 0, 0, "R1 idle after reset");
    cyc(1, {PA,OF}, 1, 0,0,'0,'0, 0,0,0,  0, '0, 0, 1, 0, "R1 first fetch misses");
    // R4: wait cycle with good fill, then translated
    cyc(1, {PA,OF}, 1, 1,0,PA,RA, 0,0,0,  0, '0, 0, 0, 0, "R4 second low cycle");
    cyc(1, {PA,OF}, 1, 0,0,'0,'0, 0,0,0,  1, {RA,OF}, 1, 0, 0, "R4 valid on third cycle");
    // R2 / R11
    cyc(1, XU, 0, 0,0,'0,'0, 0,0,0,  1, XU, 1, 0, 0, "R2 passthrough");
    cyc(0, XU, 1, 0,0,'0,'0, 0,0,0,  0, '0, 0, 0, 0, "R11 no input no request");
    // B into entry 1
    cyc(1, {PB,OF}, 1, 0,0,'0,'0, 0,0,0,  0, '0, 0, 1, 0, "R4 miss B");
    cyc(1, {PB,OF}, 1, 1,0,PB,RB, 0,0,0,  0, '0, 0, 0, 0, "R4 wait B");
    cyc(1, {PB,OF}, 1, 0,0,'0,'0, 0,0,0,  1, {RB,OF}, 1, 0, 0, "R3 hit B");
    cyc(1, {PA,OF}, 1, 0,0,'0,'0, 0,0,0,  1, {RA,OF}, 1, 0, 0, "R3 hit A");
    // R5/R6: C replaces LRU entry (B)
    cyc(1, {PC,OF}, 1, 0,0,'0,'0, 0,0,0,  0, '0, 0, 1, 0, "R5 miss C");
    cyc(1, {PC,OF}, 1, 1,0,PC,RC, 0,0,0,  0, '0, 0, 0, 0, "R5 wait C");
    cyc(1, {PC,OF}, 1, 0,0,'0,'0, 0,0,0,  1, {RC,OF}, 1, 0, 0, "R5 hit C");
    cyc(1, {PA,OF}, 1, 0,0,'0,'0, 0,0,0,  1, {RA,OF}, 1, 0, 0, "R6 A kept");
    cyc(1, {PB,OF}, 1, 0,0,'0,'0, 0,0,0,  0, '0, 0, 1, 0, "R6 B was evicted");
    cyc(1, {PB,OF}, 1, 1,0,PB,RB, 0,0,0,  0, '0, 0, 0, 0, "R6 wait B");
    cyc(1, {PB,OF}, 1, 0,0,'0,'0, 0,0,0,  1, {RB,OF}, 1, 0, 0, "R6 B replaced C");
    // R9/R5: unsolicited PTE for B overwrites its own entry, not LRU A
    cyc(0, '0, 1, 1,0,PB,RB2, 0,0,0,  0, '0, 0, 0, 0, "R9 PTE while idle");
    cyc(1, {PA,OF}, 1, 0,0,'0,'0, 0,0,0,  1, {RA,OF}, 1, 0, 0, "R5 A not overwritten");
    cyc(1, {PB,OF}, 1, 0,0,'0,'0, 0,0,0,  1, {RB2,OF}, 1, 0, 0, "R9 B updated");
    // R7/R8: missing answer -> stall, redirect exits
    cyc(1, {PD,OF}, 1, 0,0,'0,'0, 0,0,0,  0, '0, 0, 1, 0, "R7 miss D");
    cyc(1, {PD,OF}, 1, 0,0,'0,'0, 0,0,0,  0, '0, 0, 0, 0, "R7 no answer");
    cyc(1, {PD,OF}, 1, 0,0,'0,'0, 0,0,0,  0, '0, 0, 0, 1, "R7 fetch_fail raised");
    cyc(1, {PA,OF}, 1, 0,0,'0,'0, 0,0,0,  0, '0, 0, 0, 1, "R7 stall holds");
    cyc(1, {PD,OF}, 1, 0,0,'0,'0, 0,0,1,  0, '0, 0, 0, 1, "R8 redirect cycle");
    cyc(1, {PD,OF}, 1, 0,0,'0,'0, 0,0,0,  0, '0, 0, 1, 0, "R8 redirect exits");
    // protection fault, irq exits
    cyc(1, {PD,OF}, 1, 1,1,PD,RD, 0,0,0,  0, '0, 0, 0, 0, "R7 fault answer");
    cyc(1, {PD,OF}, 1, 0,0,'0,'0, 0,1,0,  0, '0, 0, 0, 1, "R7 protection stall");
    cyc(1, {PD,OF}, 1, 0,0,'0,'0, 0,0,0,  0, '0, 0, 1, 0, "R8 irq exits");
    // PTE ends stall and is loaded
    cyc(1, {PD,OF}, 1, 0,0,'0,'0, 0,0,0,  0, '0, 0, 0, 0, "R7 no answer again");
    cyc(1, {PD,OF}, 1, 1,0,PD,RD, 0,0,0,  0, '0, 0, 0, 1, "R8 PTE during stall");
    cyc(1, {PD,OF}, 1, 0,0,'0,'0, 0,0,0,  1, {RD,OF}, 1, 0, 0, "R8 PTE loaded");
    // R10: invalidate, and invalidate beats fill
    cyc(0, '0, 1, 0,0,'0,'0, 1,0,0,  0, '0, 0, 0, 0, "R10 inval");
    cyc(1, {PD,OF}, 1, 0,0,'0,'0, 0,0,0,  0, '0, 0, 1, 0, "R10 D gone");
    cyc(1, {PD,OF}, 1, 1,0,PD,RD, 1,0,0,  0, '0, 0, 0, 0, "R10 inval with fill");
    cyc(1, {PD,OF}, 1, 0,0,'0,'0, 0,0,0,  0, '0, 0, 1, 0, "R10 fill discarded");
    cyc(1, {PD,OF}, 1, 1,0,PD,RD, 0,0,0,  0, '0, 0, 0, 0, "R4 refill D");
    cyc(1, {PD,OF}, 1, 0,0,'0,'0, 0,0,0,  1, {RD,OF}, 1, 0, 0, "R3 hit D");
    cyc(0, '0, 0, 0,0,'0,'0, 0,0,0,  0, '0, 0, 0, 0, "R11 idle end");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule